// File: doc/BRIEF.md
# Binary Tape Program Executor

This block runs a small stored program against a bounded binary tape with a single read/write head. Each tape cell is either marked (1) or unmarked (0). A program is a numbered list of one-operation instructions: write a 0 or a 1 under the head, step the head one cell left or right, or branch to a numbered instruction depending on the scanned cell. Instructions run one per clock in numbered order. A taken branch replaces the following number with its target.

There is no stop instruction. The machine halts once its instruction number reaches a slot the program does not hold. The same happens when the slot holds one of the two unused opcodes. The tape is two-way but finite. The head starts mid-tape, so a program can walk left as freely as right. Walking off either end raises a fault and stops the run.

A host fills the program memory, the program length and the tape while the machine is idle, using simple write strobes. It then pulses start and watches busy until the run ends. Afterwards it reads the tape cell by cell, along with the step count and the fault and timeout flags. A nonzero step limit ends a run that does not stop by itself.

Top module: `tape_program_runner`

## Requirements
- R1: After synchronous reset, busy, fault and timeout are 0, halted is 1, step_count is 0, every tape cell reads 0 and the program length is 0.
- R2: A start pulse while idle sets busy in the next cycle. Execution begins at instruction 0 with the head on cell 128. busy never rises without start.
- R3: An instruction word holds the opcode in bits [10:8] and the branch target in bits [7:0]. Opcode 000 writes 0 and 001 writes 1 into the scanned cell, then execution moves to the next instruction.
- R4: Opcode 010 moves the head one cell toward cell 0, and opcode 011 moves it one cell toward cell 255. Execution then moves to the next instruction.
- R5: Opcode 100 branches to its target when the scanned cell is 0, and opcode 101 branches when it is 1. Otherwise execution moves to the next instruction.
- R6: The machine halts normally, with no step counted, in any of these cases: the instruction number is greater than or equal to the program length (this includes a branch target at or beyond it), or the opcode is 110 or 111. busy falls in the cycle after that instruction number is reached.
- R7: A move left from cell 0 or right from cell 255 sets fault and halts. The tape and the step count are left unchanged.
- R8: step_count is cleared by start and rises by exactly one for each executed instruction.
- R9: With step_limit nonzero, a run whose step_count equals step_limit halts with timeout set instead of executing further. A normal halt takes precedence. A step_limit of 0 means no limit. fault and timeout are never both set.
- R10: While busy, start, tape writes, program writes and length writes are all ignored.
- R11: tape_rbit always shows the cell addressed by tape_raddr. Tape writes while idle update that cell at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when idle |
| prog_we | input | 1 | Program word write strobe |
| prog_addr | input | 8 | Program slot to write |
| prog_wdata | input | 11 | Instruction word {opcode[2:0], target[7:0]} |
| len_we | input | 1 | Program length write strobe |
| len_wdata | input | 9 | Number of valid program slots (0 to 256) |
| tape_we | input | 1 | Tape cell write strobe |
| tape_waddr | input | 8 | Tape cell to write |
| tape_wbit | input | 1 | Value to write |
| tape_raddr | input | 8 | Tape cell to read back |
| tape_rbit | output | 1 | Value of the addressed cell |
| step_limit | input | 32 | Step budget, 0 disables |
| busy | output | 1 | A run is in progress |
| halted | output | 1 | Machine is idle |
| fault | output | 1 | Last run moved off the tape |
| timeout | output | 1 | Last run hit the step limit |
| step_count | output | 32 | Instructions executed in the current or last run |

## Verification
A wrong program counter or head position inside this block surfaces at the ports within a cycle or two. It shows as a step_count that stops rising early or runs on, or as busy falling one cycle off. It can also appear as a tape cell that reads back a different value than the reference predicts. Because busy and step_count are compared every clock, a single misplaced branch or head move shows up at the very edge where the run's length diverges. Edge faults, timeouts and ignored mid-run writes are each judged from busy duration, flags and tape contents after the run.

// File: rtl/tape_program_runner.sv
module tape_program_runner #(
  parameter int PROG_DEPTH = 256,
  parameter int TAPE_CELLS = 256,
  parameter int HEAD_HOME  = 128,
  parameter int STEP_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          prog_we,
  input  logic [$clog2(PROG_DEPTH)-1:0] prog_addr,
  input  logic [$clog2(PROG_DEPTH)+2:0] prog_wdata,
  input  logic                          len_we,
  input  logic [$clog2(PROG_DEPTH):0]   len_wdata,
  input  logic                          tape_we,
  input  logic [$clog2(TAPE_CELLS)-1:0] tape_waddr,
  input  logic                          tape_wbit,
  input  logic [$clog2(TAPE_CELLS)-1:0] tape_raddr,
  output logic                          tape_rbit,
  input  logic [STEP_W-1:0]             step_limit,
  output logic                          busy,
  output logic                          halted,
  output logic                          fault,
  output logic                          timeout,
  output logic [STEP_W-1:0]             step_count
);
  localparam int PA_W   = $clog2(PROG_DEPTH);
  localparam int PC_W   = PA_W + 1;
  localparam int TA_W   = $clog2(TAPE_CELLS);
  localparam int WORD_W = PA_W + 3;

  logic [WORD_W-1:0]     prog_mem [PROG_DEPTH];
  logic [TAPE_CELLS-1:0] tape;
  logic [PC_W-1:0]       pc, prog_len;
  logic [TA_W-1:0]       head;
  logic                  running, fault_q, to_q;
  logic [STEP_W-1:0]     steps;

  logic [WORD_W-1:0] word;
  logic [2:0]        op;
  logic [PC_W-1:0]   target, pc_inc;
  logic              scan, past_end, at_limit, at_left, at_right;

  assign word     = prog_mem[pc[PA_W-1:0]];
  assign op       = word[WORD_W-1 -: 3];
  assign target   = PC_W'(word[PA_W-1:0]);
  assign pc_inc   = pc + 1'b1;
  assign scan     = tape[head];
  assign past_end = (pc >= prog_len) || (op[2] && op[1]);
  assign at_limit = (step_limit != '0) && (steps == step_limit);
  assign at_left  = (head == '0);
  assign at_right = (head == TA_W'(TAPE_CELLS - 1));

  assign busy       = running;
  assign halted     = !running;
  assign fault      = fault_q;
  assign timeout    = to_q;
  assign step_count = steps;
  assign tape_rbit  = tape[tape_raddr];

  always_ff @(posedge clk)
    if (!rst && !running && prog_we)
      prog_mem[prog_addr] <= prog_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      pc       <= '0;
      head     <= TA_W'(HEAD_HOME);
      fault_q  <= 1'b0;
      to_q     <= 1'b0;
      steps    <= '0;
      prog_len <= '0;
      tape     <= '0;
    end else if (!running) begin
      if (len_we)  prog_len         <= len_wdata;
      if (tape_we) tape[tape_waddr] <= tape_wbit;
      if (start) begin
        running <= 1'b1;
        pc      <= '0;
        head    <= TA_W'(HEAD_HOME);
        fault_q <= 1'b0;
        to_q    <= 1'b0;
        steps   <= '0;
      end
    end else if (past_end) begin
      running <= 1'b0;
    end else if (at_limit) begin
      running <= 1'b0;
      to_q    <= 1'b1;
    end else begin
      case (op)
        3'b000, 3'b001: begin
          tape[head] <= op[0];
          pc         <= pc_inc;
          steps      <= steps + 1'b1;
        end
        3'b010: begin
          if (at_left) begin
            running <= 1'b0;
            fault_q <= 1'b1;
          end else begin
            head  <= head - 1'b1;
            pc    <= pc_inc;
            steps <= steps + 1'b1;
          end
        end
        3'b011: begin
          if (at_right) begin
            running <= 1'b0;
            fault_q <= 1'b1;
          end else begin
            head  <= head + 1'b1;
            pc    <= pc_inc;
            steps <= steps + 1'b1;
          end
        end
        3'b100, 3'b101: begin
          pc    <= (scan == op[0]) ? target : pc_inc;
          steps <= steps + 1'b1;
        end
        default: running <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tape_program_runner_chk.sv
module tape_program_runner_chk #(
  parameter int STEP_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              fault,
  input logic              timeout,
  input logic [STEP_W-1:0] step_count
);
  // R8
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy && step_count == $past(step_count) + 1'b1) ||
             (!busy && step_count == $past(step_count)));

  // R8
  step_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (step_count == '0));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);

  // R7
  flag_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (fault || timeout) |-> !busy);

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fault && timeout));
endmodule

bind tape_program_runner tape_program_runner_chk #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .fault(fault), .timeout(timeout), .step_count(step_count)
);

// File: tb/sim_tape_program_runner.sv
`timescale 1ns/1ps
module sim_tape_program_runner;
  logic        clk = 0, rst = 1, start = 0;
  logic        prog_we = 0, len_we = 0, tape_we = 0, tape_wbit = 0;
  logic [7:0]  prog_addr = 0, tape_waddr = 0, tape_raddr = 0;
  logic [10:0] prog_wdata = 0;
  logic [8:0]  len_wdata = 0;
  logic [31:0] step_limit = 0;
  logic        tape_rbit, busy, halted, fault, timeout;
  logic [31:0] step_count;

  tape_program_runner u0 (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int     m_prog [256];
  bit     m_tape [256];
  int     m_pc, m_head, m_len;
  bit     m_run, m_f, m_t;
  longint m_step;

  always @(posedge clk) begin
    int op, tg;
    if (rst) begin
      m_run = 0; m_pc = 0; m_head = 128; m_f = 0; m_t = 0; m_step = 0; m_len = 0;
      foreach (m_tape[i]) m_tape[i] = 0;
    end else if (!m_run) begin
      if (prog_we) m_prog[prog_addr] = prog_wdata;
      if (len_we)  m_len = len_wdata;
      if (tape_we) m_tape[tape_waddr] = tape_wbit;
      if (start) begin
        m_run = 1; m_pc = 0; m_head = 128; m_f = 0; m_t = 0; m_step = 0;
      end
    end else begin
      op = (m_pc < m_len) ? (m_prog[m_pc] >> 8) : 7;
      tg = (m_pc < m_len) ? (m_prog[m_pc] & 255) : 0;
      if (op >= 6) m_run = 0;
      else if (step_limit != 0 && m_step == step_limit) begin m_run = 0; m_t = 1; end
      else begin
        case (op)
          0, 1: begin m_tape[m_head] = op[0]; m_pc++; m_step++; end
          2: if (m_head == 0) begin m_run = 0; m_f = 1; end
             else begin m_head--; m_pc++; m_step++; end
          3: if (m_head == 255) begin m_run = 0; m_f = 1; end
             else begin m_head++; m_pc++; m_step++; end
          default: begin
            m_pc = (m_tape[m_head] == op[0]) ? tg : m_pc + 1;
            m_step++;
          end
        endcase
      end
    end
    #1;
    cyc++;
    if (!rst) begin
      n_chk++;
      if (busy !== m_run || halted !== !m_run) begin
        n_fail++; $display("FAIL R6 busy actual=%0d expected=%0d", busy, m_run);
      end
      if (fault !== m_f) begin
        n_fail++; $display("FAIL R7 fault actual=%0d expected=%0d", fault, m_f);
      end
      if (timeout !== m_t) begin
        n_fail++; $display("FAIL R9 timeout actual=%0d expected=%0d", timeout, m_t);
      end
      if (step_count !== 32'(m_step)) begin
        n_fail++; $display("FAIL R8 step_count actual=%0d expected=%0d", step_count, m_step);
      end
      if (tape_rbit !== m_tape[tape_raddr]) begin
        n_fail++; $display("FAIL R11 tape[%0d] actual=%0d expected=%0d", tape_raddr, tape_rbit, m_tape[tape_raddr]);
      end
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic load(input int addr, input int op, input int tg);
    @(negedge clk);
    prog_we = 1; prog_addr = 8'(addr); prog_wdata = 11'((op << 8) | tg);
    @(negedge clk); prog_we = 0;
  endtask

  task automatic set_len(input int n);
    @(negedge clk); len_we = 1; len_wdata = 9'(n);
    @(negedge clk); len_we = 0;
  endtask

  task automatic poke_tape(input int addr, input bit v);
    @(negedge clk); tape_we = 1; tape_waddr = 8'(addr); tape_wbit = v;
    @(negedge clk); tape_we = 0;
  endtask

  task automatic run(input int limit, input int poke_at, output int cycles);
    step_limit = limit;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cycles = 0;
    while (busy && cycles < 20000) begin
      cycles++;
      if (cycles == poke_at) begin
        start = 1; tape_we = 1; tape_waddr = 5; tape_wbit = 1;
        prog_we = 1; prog_addr = 0; prog_wdata = 11'h100;
        len_we = 1; len_wdata = 9'd200;
      end
      @(negedge clk);
      start = 0; tape_we = 0; prog_we = 0; len_we = 0;
    end
  endtask

  task automatic peek(input int addr, input bit exp, input string tag);
    tape_raddr = 8'(addr);
    #0.5;
    chk(tape_rbit === exp, tag, tape_rbit, exp);
  endtask

  initial begin
    int c;
    do_reset();
    @(negedge clk);
    chk(busy === 0 && halted === 1, "R1 idle after reset", busy, 0);
    chk(fault === 0 && timeout === 0, "R1 flags after reset", {fault, timeout}, 0);
    chk(step_count === 0, "R1 step_count after reset", step_count, 0);
    peek(128, 0, "R1 tape cleared");
    peek(0, 0, "R1 tape cleared");

    // R3 R4 R5: straight line with taken jump-if-1 to target equal to length
    load(0, 1, 0); load(1, 3, 0); load(2, 1, 0); load(3, 3, 0);
    load(4, 0, 0); load(5, 2, 0); load(6, 5, 8); load(7, 0, 0);
    set_len(8);
    run(0, 0, c);
    chk(step_count === 7, "R8 straight program steps", step_count, 7);
    chk(c === 8, "R6 halt on target past end", c, 8);
    peek(128, 1, "R3 write1 at home");
    peek(129, 1, "R4 write1 after right");
    peek(130, 0, "R3 write0 erased");

    // R9 R10: endless jump loop with limit, mid-run writes and start ignored
    do_reset();
    load(0, 4, 0); set_len(1);
    run(50, 10, c);
    chk(timeout === 1 && fault === 0, "R9 timeout flag", timeout, 1);
    chk(step_count === 50, "R9 steps at limit", step_count, 50);
    chk(c === 51, "R10 start ignored while busy", c, 51);
    peek(5, 0, "R10 tape write ignored while busy");
    run(3, 0, c);
    peek(128, 0, "R10 program write ignored while busy");
    chk(timeout === 1 && step_count === 3, "R10 length write ignored", step_count, 3);

    // R7 left edge
    do_reset();
    load(0, 2, 0); load(1, 4, 0); set_len(2);
    run(0, 0, c);
    chk(fault === 1 && timeout === 0, "R7 left edge fault", fault, 1);
    chk(step_count === 256, "R7 steps before left fault", step_count, 256);
    peek(0, 0, "R7 tape unchanged");

    // R7 right edge with a marked far cell
    do_reset();
    poke_tape(255, 1);
    load(0, 3, 0); load(1, 4, 0); set_len(2);
    run(0, 0, c);
    chk(fault === 0, "R5 jump-if-0 not taken on marked cell", fault, 0);
    chk(step_count === 254, "R5 steps to marked cell", step_count, 254);
    peek(255, 1, "R11 loaded cell reads back");

    do_reset();
    load(0, 3, 0); load(1, 4, 0); set_len(2);
    run(0, 0, c);
    chk(fault === 1, "R7 right edge fault", fault, 1);
    chk(step_count === 254, "R7 steps before right fault", step_count, 254);

    // R6 unused opcodes
    do_reset();
    load(0, 1, 0); load(1, 6, 0); load(2, 3, 0); set_len(3);
    run(0, 0, c);
    chk(step_count === 1 && fault === 0, "R6 opcode 110 halts", step_count, 1);
    load(1, 7, 0);
    run(0, 0, c);
    chk(step_count === 1 && c === 2, "R6 opcode 111 halts", step_count, 1);

    // R6 empty program
    do_reset();
    run(0, 0, c);
    chk(step_count === 0 && c === 1, "R6 empty program", c, 1);

    // R9 normal halt wins over limit
    do_reset();
    load(0, 1, 0); load(1, 1, 0); load(2, 1, 0); set_len(3);
    run(3, 0, c);
    chk(timeout === 0 && step_count === 3, "R9 past end precedes limit", timeout, 0);

    // R5 jump-if-0 not taken then taken past end
    do_reset();
    poke_tape(128, 1);
    load(0, 4, 3); load(1, 0, 0); load(2, 4, 5); load(3, 1, 0); set_len(4);
    run(0, 0, c);
    chk(step_count === 3, "R5 conditional jumps", step_count, 3);
    peek(128, 0, "R5 fall-through erased cell");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule